// File: doc/BRIEF.md
# Sublayer Host Handshake Register Interface

This block connects an 8-bit microcontroller bus to a power-line symbol encoding sublayer. The host sees four byte-wide registers on a 2-bit address: a status register that reports events, a control register that requests mode changes, a receive buffer that passes bytes up, and a transmit buffer that passes bytes down. When the sublayer has something to report it latches an event flag and raises one interrupt line. The host then reads the status register once. That read returns the pending flags and clears them. The two top status bits always show the live channel condition.

On the sublayer side, the encoder, decoder, CRC, modem path and timestamp source are represented by simple strobes and data buses. The block pads received bytes whose leading zeros were suppressed, and it delivers timestamp bytes through the receive buffer. It holds one transmit byte for the encoder and flags an overrun when the host writes over a byte that has not been consumed. It also tracks the four operating modes, avoids starting a transmission on a busy channel, and runs a jabber monitor over consecutive dominant line states.

Top module: `sublayer_host_regs`

## Requirements
- R1: After synchronous reset the mode is INIT, host_irq is 0, tx_avail is 0, tx_byte is 0 and host_rdata is 0.
- R2: Address 0 reads the status register. Address 1 is the control register (written and read back). Address 2 reads the receive buffer. Address 3 writes the transmit buffer and reads as 0. Read data appears on host_rdata on the clock after host_rd and is held at all other times.
- R3: Status bit 0 = receive byte loaded, bit 1 = transmit byte taken, bit 2 = frame end, bit 3 = timestamp byte loaded, bit 4 = jabber, bit 5 = transmit overrun. Bit 6 = ch_active and bit 7 = ch_noisy, both sampled live in the read cycle and never latched.
- R4: An event sets its flag, and host_irq goes high on the next clock. Both stay set until a status read. That read clears the six flags and drops host_irq on the following clock.
- R5: An event that arrives in the same cycle as a status read is not lost: its flag survives the clear, and host_irq stays high.
- R6: rx_load stores rx_byte into the receive buffer with every bit position at or above rx_width forced to 0. An rx_width of 8 or more keeps all bits.
- R7: ts_load stores ts_byte into the receive buffer and sets bit 3. If rx_load occurs in the same cycle, the receive byte wins and the timestamp is ignored, so bit 3 is not set.
- R8: A write to address 3 presents the byte on tx_byte with tx_avail high on the next clock. tx_take while tx_avail is high clears tx_avail and sets bit 1. A write in the same cycle as tx_take loads the new byte without an overrun.
- R9: A write to address 3 while tx_avail is high and tx_take is low discards the new byte, leaves tx_byte unchanged and sets bit 5.
- R10: Mode encoding: INIT=0, IDLE=1, RCV=2, XMIT=3. Control bit 0 low forces INIT. In INIT, control bit 0 high moves the mode to IDLE.
- R11: In IDLE, rx_start moves to RCV. Otherwise, control bit 1 with ch_active low moves to XMIT and clears control bit 1. frame_end returns RCV or XMIT to IDLE and always sets bit 2.
- R12: While the mode is RCV or XMIT, JAB_LIMIT consecutive line_sample strobes with line_dom high set bit 4 once. A non-dominant sample or any other mode restarts the count. The flag is not raised again until the run is broken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| host_irq | output | 1 | Handshake interrupt |
| ch_active | input | 1 | Live channel-active state |
| ch_noisy | input | 1 | Live channel-noisy state |
| rx_load | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_width | input | 4 | Significant low bits of rx_byte |
| ts_load | input | 1 | Timestamp byte strobe |
| ts_byte | input | 8 | Timestamp byte |
| rx_start | input | 1 | Incoming frame detected |
| frame_end | input | 1 | Frame completed |
| tx_take | input | 1 | Encoder consumed the transmit byte |
| tx_byte | output | 8 | Byte offered to the encoder |
| tx_avail | output | 1 | Transmit byte valid |
| line_sample | input | 1 | Line state strobe |
| line_dom | input | 1 | Sampled state is dominant |
| mode | output | 2 | Current operating mode |

## Verification
The hardest state to reach is the jabber boundary. The bench enters RCV and drives one dominant sample short of the limit. It then breaks the run with a single non-dominant sample and drives a full run of exactly JAB_LIMIT samples, followed by hundreds more. This shows the flag is set only on the exact count and only once per run. The clear-versus-set race is also hard to reach. The bench places a frame-end, receive or transmit-take strobe in the very cycle of a status read, and the per-clock reference model tracks the surviving flag and the interrupt.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int BYTE_W = 8;
  localparam int EV_W   = 6;
  localparam int WID_W  = 4;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_RXBUF  = 2'd2;
  localparam logic [1:0] A_TXBUF  = 2'd3;

  localparam int EV_RX   = 0;
  localparam int EV_TAKE = 1;
  localparam int EV_END  = 2;
  localparam int EV_TS   = 3;
  localparam int EV_JAB  = 4;
  localparam int EV_OVR  = 5;

  typedef enum logic [1:0] {
    M_INIT = 2'd0,
    M_IDLE = 2'd1,
    M_RCV  = 2'd2,
    M_XMIT = 2'd3
  } mode_e;
endpackage

// File: rtl/shr_event_latch.sv
module shr_event_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;
  logic         irq_q;

  // clear is applied first so that a same-cycle set always survives
  always_comb begin
    flags_d = clr_i ? '0 : flags_q;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |flags_d;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/shr_jabber_mon.sv
module shr_jabber_mon #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic sample_i,
  input  logic dom_i,
  output logic fire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      if (!dom_i)
        cnt_q <= '0;
      else if (cnt_q != TOP)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = arm_i && sample_i && dom_i && (cnt_q == LAST);
endmodule

// File: rtl/shr_mode_ctrl.sv
module shr_mode_ctrl
  import shr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run_en_i,
  input  logic  xmit_req_i,
  input  logic  ch_active_i,
  input  logic  rx_start_i,
  input  logic  frame_end_i,
  output mode_e mode_o,
  output logic  xmit_ack_o
);
  mode_e mode_q;
  mode_e mode_d;
  logic  go_xmit;

  assign go_xmit = run_en_i && (mode_q == M_IDLE) && !rx_start_i
                   && xmit_req_i && !ch_active_i;

  always_comb begin
    mode_d = mode_q;
    if (!run_en_i) begin
      mode_d = M_INIT;
    end else begin
      unique case (mode_q)
        M_INIT: mode_d = M_IDLE;
        M_IDLE: begin
          if (rx_start_i)   mode_d = M_RCV;
          else if (go_xmit) mode_d = M_XMIT;
        end
        M_RCV, M_XMIT: if (frame_end_i) mode_d = M_IDLE;
        default: mode_d = M_INIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_INIT;
    else     mode_q <= mode_d;
  end

  assign mode_o     = mode_q;
  assign xmit_ack_o = go_xmit;
endmodule

// File: rtl/shr_tx_holder.sv
module shr_tx_holder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic [DW-1:0] byte_o,
  output logic          avail_o,
  output logic          taken_o,
  output logic          overrun_o
);
  logic [DW-1:0] byte_q;
  logic          avail_q;
  logic          accept;

  assign taken_o   = take_i && avail_q;
  assign overrun_o = wr_i && avail_q && !take_i;
  assign accept    = wr_i && (!avail_q || take_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      if (accept) begin
        byte_q  <= wdata_i;
        avail_q <= 1'b1;
      end else if (take_i) begin
        avail_q <= 1'b0;
      end
    end
  end

  assign byte_o  = byte_q;
  assign avail_o = avail_q;
endmodule

// File: rtl/sublayer_host_regs.sv
module sublayer_host_regs
  import shr_pkg::*;
#(
  parameter int JAB_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              ch_active,
  input  logic              ch_noisy,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [WID_W-1:0]  rx_width,
  input  logic              ts_load,
  input  logic [BYTE_W-1:0] ts_byte,
  input  logic              rx_start,
  input  logic              frame_end,
  input  logic              tx_take,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_avail,
  input  logic              line_sample,
  input  logic              line_dom,
  output logic [1:0]        mode
);
  logic [EV_W-1:0]   ev_set;
  logic [EV_W-1:0]   ev_flags;
  logic              stat_rd;
  logic              ctrl_wr;
  logic              tx_wr;
  logic              tx_taken;
  logic              tx_ovr;
  logic              jab_fire;
  logic              xmit_ack;
  logic              jab_arm;
  mode_e             mode_cur;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] rxbuf_q;
  logic [BYTE_W-1:0] rx_pad;
  logic [BYTE_W-1:0] rdata_q;

  assign stat_rd = host_rd && (host_addr == A_STATUS);
  assign ctrl_wr = host_wr && (host_addr == A_CTRL);
  assign tx_wr   = host_wr && (host_addr == A_TXBUF);

  // leading-zero restoration: positions beyond the significant width read 0
  for (genvar g = 0; g < BYTE_W; g++) begin : g_pad
    assign rx_pad[g] = rx_byte[g] & (rx_width > WID_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxbuf_q <= '0;
    end else if (rx_load) begin
      rxbuf_q <= rx_pad;
    end else if (ts_load) begin
      rxbuf_q <= ts_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= host_wdata;
    end else if (xmit_ack) begin
      ctrl_q[1] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (host_rd) begin
      unique case (host_addr)
        A_STATUS: rdata_q <= {ch_noisy, ch_active, ev_flags};
        A_CTRL:   rdata_q <= ctrl_q;
        A_RXBUF:  rdata_q <= rxbuf_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  always_comb begin
    ev_set          = '0;
    ev_set[EV_RX]   = rx_load;
    ev_set[EV_TAKE] = tx_taken;
    ev_set[EV_END]  = frame_end;
    ev_set[EV_TS]   = ts_load && !rx_load;
    ev_set[EV_JAB]  = jab_fire;
    ev_set[EV_OVR]  = tx_ovr;
  end

  assign jab_arm = (mode_cur == M_RCV) || (mode_cur == M_XMIT);

  shr_event_latch #(.W(EV_W)) ev_i (
    .clk     (clk),
    .rst     (rst),
    .set_i   (ev_set),
    .clr_i   (stat_rd),
    .flags_o (ev_flags),
    .irq_o   (host_irq)
  );

  shr_jabber_mon #(.LIMIT(JAB_LIMIT)) jab_i (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (jab_arm),
    .sample_i (line_sample),
    .dom_i    (line_dom),
    .fire_o   (jab_fire)
  );

  shr_mode_ctrl mode_i (
    .clk         (clk),
    .rst         (rst),
    .run_en_i    (ctrl_q[0]),
    .xmit_req_i  (ctrl_q[1]),
    .ch_active_i (ch_active),
    .rx_start_i  (rx_start),
    .frame_end_i (frame_end),
    .mode_o      (mode_cur),
    .xmit_ack_o  (xmit_ack)
  );

  shr_tx_holder #(.DW(BYTE_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (tx_wr),
    .wdata_i   (host_wdata),
    .take_i    (tx_take),
    .byte_o    (tx_byte),
    .avail_o   (tx_avail),
    .taken_o   (tx_taken),
    .overrun_o (tx_ovr)
  );

  assign host_rdata = rdata_q;
  assign mode       = mode_cur;
endmodule

// File: rtl/sublayer_host_regs_chk.sv
module sublayer_host_regs_chk #(
  parameter int LIMIT = 1000,
  parameter int CW    = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] host_addr,
  input logic       host_rd,
  input logic       host_wr,
  input logic       host_irq,
  input logic [5:0] ev_set,
  input logic [5:0] ev_flags,
  input logic       tx_take,
  input logic       tx_avail,
  input logic [7:0] tx_byte,
  input logic       rx_load,
  input logic [3:0] rx_width,
  input logic [7:0] rxbuf_q,
  input logic [1:0] mode,
  input logic       ch_active,
  input logic [CW-1:0] jab_cnt
);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd0 && ev_set == 6'd0) |=> (!host_irq && ev_flags == 6'd0));

  a_r5_event_kept: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd0 && ev_set != 6'd0) |=> host_irq);

  a_r8_write_sets_avail: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd3) |=> tx_avail);

  a_r9_overrun_holds: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd3 && tx_avail && !tx_take) |=> ($stable(tx_byte) && ev_flags[5]));

  a_r6_zero_width: assert property (@(posedge clk) disable iff (rst)
    (rx_load && rx_width == 4'd0) |=> (rxbuf_q == 8'd0));

  a_r11_xmit_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd1 && !$past(ch_active)));

  a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
    jab_cnt <= CW'(LIMIT));
endmodule

bind sublayer_host_regs sublayer_host_regs_chk #(
  .LIMIT (JAB_LIMIT),
  .CW    ($clog2(JAB_LIMIT + 1))
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .host_addr (host_addr),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .host_irq  (host_irq),
  .ev_set    (ev_set),
  .ev_flags  (ev_flags),
  .tx_take   (tx_take),
  .tx_avail  (tx_avail),
  .tx_byte   (tx_byte),
  .rx_load   (rx_load),
  .rx_width  (rx_width),
  .rxbuf_q   (rxbuf_q),
  .mode      (mode),
  .ch_active (ch_active),
  .jab_cnt   (jab_i.cnt_q)
);

// File: tb/sublayer_host_regs_tb_top.sv
module sublayer_host_regs_tb_top;
  localparam int LIM = 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_addr = '0;
  logic       host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_irq;
  logic       ch_active = 0, ch_noisy = 0;
  logic       rx_load = 0;
  logic [7:0] rx_byte = '0;
  logic [3:0] rx_width = '0;
  logic       ts_load = 0;
  logic [7:0] ts_byte = '0;
  logic       rx_start = 0, frame_end = 0, tx_take = 0;
  logic [7:0] tx_byte;
  logic       tx_avail;
  logic       line_sample = 0, line_dom = 0;
  logic [1:0] mode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sublayer_host_regs #(.JAB_LIMIT(LIM)) dut_i (.*);

  // behavioural reference model
  int m_mode, m_flags, m_ctrl, m_rx, m_rdata, m_txb, m_jc;
  bit m_irq, m_avail;

  always @(posedge clk) begin
    int nf, nm, nc, set;
    bit fire, arm;
    cycles++;
    if (rst) begin
      m_mode = 0; m_flags = 0; m_ctrl = 0; m_rx = 0; m_rdata = 0;
      m_txb = 0; m_jc = 0; m_irq = 0; m_avail = 0;
    end else begin
      set = 0;
      arm = (m_mode == 2 || m_mode == 3);
      fire = arm && line_sample && line_dom && (m_jc == LIM - 1);
      if (rx_load) set |= 1;
      if (tx_take && m_avail) set |= 2;
      if (frame_end) set |= 4;
      if (ts_load && !rx_load) set |= 8;
      if (fire) set |= 16;
      if (host_wr && host_addr == 3 && m_avail && !tx_take) set |= 32;
      if (host_rd) begin
        case (host_addr)
          0: m_rdata = (int'(ch_noisy) << 7) | (int'(ch_active) << 6) | m_flags;
          1: m_rdata = m_ctrl;
          2: m_rdata = m_rx;
          default: m_rdata = 0;
        endcase
      end
      nf = ((host_rd && host_addr == 0) ? 0 : m_flags) | set;
      nm = m_mode; nc = m_ctrl;
      if ((m_ctrl & 1) == 0) nm = 0;
      else if (m_mode == 0) nm = 1;
      else if (m_mode == 1) begin
        if (rx_start) nm = 2;
        else if ((m_ctrl & 2) && !ch_active) begin nm = 3; nc = m_ctrl & ~2; end
      end else if (frame_end) nm = 1;
      if (host_wr && host_addr == 1) nc = host_wdata;
      if (!arm) m_jc = 0;
      else if (line_sample) m_jc = line_dom ? ((m_jc < LIM) ? m_jc + 1 : m_jc) : 0;
      if (rx_load) begin
        m_rx = 0;
        for (int i = 0; i < 8; i++) if (i < rx_width) m_rx |= int'(rx_byte[i]) << i;
      end else if (ts_load) m_rx = ts_byte;
      if (host_wr && host_addr == 3 && (!m_avail || tx_take)) begin
        m_txb = host_wdata; m_avail = 1;
      end else if (tx_take) m_avail = 0;
      m_flags = nf; m_irq = (nf != 0); m_mode = nm; m_ctrl = nc;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 irq", int'(host_irq), int'(m_irq));
      chk("R10 mode", int'(mode), m_mode);
      chk("R8 tx_avail", int'(tx_avail), int'(m_avail));
      chk("R8 tx_byte", int'(tx_byte), m_txb);
      chk("R2 rdata", int'(host_rdata), m_rdata);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    host_rd = 0; host_wr = 0; rx_load = 0; ts_load = 0; rx_start = 0;
    frame_end = 0; tx_take = 0; line_sample = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1; step();
  endtask

  task automatic rd(input logic [1:0] a);
    host_addr = a; host_rd = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 mode", int'(mode), 0);
    chk("R1 irq", int'(host_irq), 0);
    chk("R1 tx_avail", int'(tx_avail), 0);
    chk("R1 rdata", int'(host_rdata), 0);

    // R10: leave INIT
    wr(2'd1, 8'h01); step();
    chk("R10 idle", int'(mode), 1);

    // R6: padded receive byte
    rx_byte = 8'hFF; rx_width = 4'd3; rx_load = 1; step();
    chk("R4 irq up", int'(host_irq), 1);
    rd(2'd0); chk("R3 status rx", int'(host_rdata), 8'h01);
    chk("R4 irq cleared", int'(host_irq), 0);
    rd(2'd2); chk("R6 padded", int'(host_rdata), 8'h07);
    rx_byte = 8'hA5; rx_width = 4'd8; rx_load = 1; step();
    rd(2'd2); chk("R6 full width", int'(host_rdata), 8'hA5);
    rd(2'd0);

    // R3 and R5: live bits, event during read
    ch_active = 1; frame_end = 1; step();
    host_addr = 0; host_rd = 1; rx_byte = 8'h12; rx_width = 4'd8; rx_load = 1; step();
    chk("R3 live bits", int'(host_rdata), 8'h44);
    chk("R5 irq kept", int'(host_irq), 1);
    ch_active = 0; ch_noisy = 1;
    rd(2'd0); chk("R5 surviving flag", int'(host_rdata), 8'h81);
    ch_noisy = 0;

    // R7: timestamp vs receive
    rx_byte = 8'h3C; ts_byte = 8'h99; rx_load = 1; ts_load = 1; step();
    rd(2'd0); chk("R7 ts ignored flag", int'(host_rdata), 8'h01);
    rd(2'd2); chk("R7 rx wins", int'(host_rdata), 8'h3C);
    ts_byte = 8'h5A; ts_load = 1; step();
    rd(2'd0); chk("R7 ts flag", int'(host_rdata), 8'h08);
    rd(2'd2); chk("R7 ts byte", int'(host_rdata), 8'h5A);
    rd(2'd3); chk("R2 txbuf reads zero", int'(host_rdata), 0);

    // R8 and R9: transmit holder
    wr(2'd3, 8'h11);
    chk("R8 byte", int'(tx_byte), 8'h11);
    chk("R8 avail", int'(tx_avail), 1);
    wr(2'd3, 8'h22);
    chk("R9 byte kept", int'(tx_byte), 8'h11);
    rd(2'd0); chk("R9 overrun flag", int'(host_rdata), 8'h20);
    tx_take = 1; step();
    chk("R8 taken", int'(tx_avail), 0);
    rd(2'd0); chk("R8 take flag", int'(host_rdata), 8'h02);
    wr(2'd3, 8'h33);
    host_addr = 3; host_wdata = 8'h44; host_wr = 1; tx_take = 1; step();
    chk("R8 write with take", int'(tx_byte), 8'h44);
    rd(2'd0); chk("R8 no overrun", int'(host_rdata), 8'h02);
    tx_take = 1; step(); rd(2'd0);

    // R11: transmit request and channel busy
    ch_active = 1; wr(2'd1, 8'h03); step(); step();
    chk("R11 busy stays idle", int'(mode), 1);
    ch_active = 0; step(); step();
    chk("R11 xmit", int'(mode), 3);
    rd(2'd1); chk("R11 req cleared", int'(host_rdata), 8'h01);
    frame_end = 1; step();
    chk("R11 back to idle", int'(mode), 1);
    rd(2'd0);
    rx_start = 1; step();
    chk("R11 rcv", int'(mode), 2);

    // R12: jabber window
    for (int i = 0; i < LIM - 1; i++) begin line_sample = 1; line_dom = 1; step(); end
    line_sample = 1; line_dom = 0; step();
    rd(2'd0); chk("R12 short run", int'(host_rdata), 8'h00);
    for (int i = 0; i < LIM; i++) begin line_sample = 1; line_dom = 1; step(); end
    rd(2'd0); chk("R12 fired", int'(host_rdata), 8'h10);
    for (int i = 0; i < 500; i++) begin line_sample = 1; line_dom = 1; step(); end
    rd(2'd0); chk("R12 once per run", int'(host_rdata), 8'h00);

    // R10: clearing control bit 0 forces INIT
    wr(2'd1, 8'h00); step();
    chk("R10 forced init", int'(mode), 0);

    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule